// File: doc/BRIEF.md
# Debug Authentication Gate

This block sits in front of the register file of a debug module and keeps an external debugger out until the debugger completes a small challenge-response exchange. The debugger reads a challenge word from the authentication data register. It then writes back that word plus a fixed secret. A match unlocks the register file. A mismatch leaves the gate locked and replaces the challenge with a new one. A configuration input selects whether this exchange is mandatory. When it is not mandatory, the gate comes out of reset already unlocked.

The gate owns the control register. That register holds the activation bit and the halt and resume request fields. The gate also owns a read-only status word and a small bank of guarded data registers. Those registers stand in for the abstract command, program buffer and system bus state of a full debug module. Requests arrive on a simple register bus with separate read and write enables. Every request gets a registered response one cycle later, with a success flag and read data.

A module reset happens on the synchronous reset input, and also when the activation bit is written from 0 to 1. A module reset recomputes the unlocked state from the configuration input and loads a fresh challenge from a free-running 32-bit LFSR. It also clears the halt and resume requests and the data bank.

Top module: `dbg_auth_gate`

## Requirements
- R1: After reset, the status word (address 0x11) has version 2 in bits 3:0, the implicit-break bit 22 set, and the unlocked flag in bit 7 equal to the inverse of `auth_required`. The control register reads zero.
- R2: A read of address 0x30 returns the current challenge. Two reads with no write in between return the same value.
- R3: When authentication is required, writing 0x30 with the challenge plus SECRET (default 1, modulo 2^32) sets the unlocked flag, and the response is success.
- R4: When authentication is required, writing 0x30 with any other value clears the unlocked flag and loads a challenge different from the previous one. The response is success.
- R5: When `auth_required` is 0, a write to 0x30 changes neither the unlocked flag nor the challenge, and the response is success.
- R6: While locked, a write to any address other than 0x30 or 0x10 gets `rsp_ok`=0 and leaves the target register unchanged.
- R7: While locked, a write to the control register (0x10) updates only the active bit (bit 0). The halt request (bit 1) and resume request (bit 2) keep their values, and the response is success.
- R8: A control write that takes the active bit from 0 to 1 performs a module reset. The challenge is reloaded with a new value, the unlocked flag becomes the inverse of `auth_required`, and the halt request, resume request and data bank are cleared.
- R9: While unlocked, a control write sets active from bit 0. It sets halt and resume from bits 1 and 2 when the written active bit is 1, and clears them when it is 0.
- R10: Every request gets `rsp_valid` on the following cycle. Reads always succeed, and reads of unmapped addresses return zero. Writes to the status word or to unmapped addresses fail.
- R11: While unlocked, the data registers at 0x04 to 0x04+NDATA-1 store written words and return them on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, acts as a module reset |
| auth_required | input | 1 | 1 makes the challenge exchange mandatory |
| req_addr | input | ADDR_W | Register address of the request |
| req_wdata | input | 32 | Write data |
| req_we | input | 1 | Write request; takes priority over read |
| req_re | input | 1 | Read request |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_ok | output | 1 | Request accepted |
| rsp_rdata | output | 32 | Read data, zero for writes |
| ctl_active | output | 1 | Activation bit of the control register |
| ctl_halt_req | output | 1 | Halt request field |
| ctl_resume_req | output | 1 | Resume request field |

## Verification
The hardest state to reach is a locked gate that still carries a pending halt request. The halt request can only be set while unlocked, so the stimulus sets it first and then deliberately fails an authentication attempt. That sequence lets the bench show that locked control writes neither clear nor change the field, and that only a 0-to-1 activation reset removes it. The bench never predicts the LFSR. It reads each challenge back through the bus and derives the correct and wrong responses from what it read. Constrained random traffic to the data bank runs both unlocked and locked, and a bench model tracks what each register should hold.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h11;
  localparam logic [ADDR_W-1:0] ADDR_AUTH = 8'h30;
  localparam int DATA_BASE   = 4;
  localparam logic [3:0] VERSION = 4'd2;
  localparam int STAT_AUTH_BIT = 7;
  localparam int STAT_IMPB_BIT = 22;
  localparam int CTL_ACT_BIT = 0;
  localparam int CTL_HLT_BIT = 1;
  localparam int CTL_RSM_BIT = 2;
endpackage

// File: rtl/dag_lfsr.sv
module dag_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] SEED = 32'h1d87_2b41,
  parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)           state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else               state <= state >> 1;
  end
endmodule

// File: rtl/dag_auth.sv
module dag_auth #(
  parameter int          W      = 32,
  parameter logic [W-1:0] SEED   = 32'h1d87_2b41,
  parameter logic [W-1:0] SECRET = 32'd1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         required,
  input  logic         mod_reset,
  input  logic         auth_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] fresh,
  output logic         unlocked,
  output logic [W-1:0] challenge
);
  logic [W-1:0] answer;
  assign answer = challenge + SECRET;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked  <= ~required;
      challenge <= SEED;
    end else if (mod_reset) begin
      unlocked  <= ~required;
      challenge <= fresh;
    end else if (auth_wr && required) begin
      if (wdata == answer) begin
        unlocked <= 1'b1;
      end else begin
        unlocked  <= 1'b0;
        challenge <= fresh;
      end
    end
  end
endmodule

// File: rtl/dag_ctrl.sv
module dag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic mod_reset,
  input  logic auth_eff,
  input  logic w_act,
  input  logic w_hlt,
  input  logic w_rsm,
  output logic active,
  output logic halt_req,
  output logic resume_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      halt_req   <= 1'b0;
      resume_req <= 1'b0;
    end else if (ctl_wr) begin
      active <= w_act;
      if (auth_eff) begin
        halt_req   <= w_act & w_hlt;
        resume_req <= w_act & w_rsm;
      end else if (mod_reset) begin
        halt_req   <= 1'b0;
        resume_req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dag_bank.sv
module dag_bank #(
  parameter int N = 4,
  parameter int W = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [N*W-1:0] flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (clr)                          q <= '0;
      else if (wr && idx == IW'(g))     q <= wdata;
    end
    assign flat[g*W +: W] = q;
  end
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
  import dag_pkg::*;
#(
  parameter int          NDATA  = 4,
  parameter logic [31:0] SECRET = 32'd1,
  parameter logic [31:0] SEED   = 32'h1d87_2b41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auth_required,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_we,
  input  logic              req_re,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [31:0]       rsp_rdata,
  output logic              ctl_active,
  output logic              ctl_halt_req,
  output logic              ctl_resume_req
);
  localparam int IW = (NDATA > 1) ? $clog2(NDATA) : 1;

  logic [31:0] fresh, challenge;
  logic        unlocked;
  logic        is_auth, is_ctl, is_stat, is_data;
  logic        mod_reset, auth_eff, allowed, wr_ok;
  logic [IW-1:0] didx;
  logic [NDATA*32-1:0] bank;
  logic [31:0] status_w, rd_mux;
  int unsigned addr_i;

  assign addr_i  = int'(req_addr);
  assign is_auth = (req_addr == ADDR_AUTH);
  assign is_ctl  = (req_addr == ADDR_CTL);
  assign is_stat = (req_addr == ADDR_STAT);
  assign is_data = (addr_i >= DATA_BASE) && (addr_i < DATA_BASE + NDATA);
  assign didx    = IW'(addr_i - DATA_BASE);

  assign mod_reset = req_we && is_ctl && !ctl_active && req_wdata[CTL_ACT_BIT];
  assign auth_eff  = mod_reset ? ~auth_required : unlocked;
  assign allowed   = unlocked || is_auth || is_ctl;
  assign wr_ok     = allowed && (is_auth || is_ctl || is_data);

  dag_lfsr #(.W(32), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state(fresh)
  );

  dag_auth #(.W(32), .SEED(SEED), .SECRET(SECRET)) u_auth (
    .clk(clk), .rst(rst), .required(auth_required), .mod_reset(mod_reset),
    .auth_wr(req_we && is_auth), .wdata(req_wdata), .fresh(fresh),
    .unlocked(unlocked), .challenge(challenge)
  );

  dag_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(req_we && is_ctl), .mod_reset(mod_reset),
    .auth_eff(auth_eff), .w_act(req_wdata[CTL_ACT_BIT]),
    .w_hlt(req_wdata[CTL_HLT_BIT]), .w_rsm(req_wdata[CTL_RSM_BIT]),
    .active(ctl_active), .halt_req(ctl_halt_req), .resume_req(ctl_resume_req)
  );

  dag_bank #(.N(NDATA), .W(32)) u_bank (
    .clk(clk), .clr(rst || mod_reset), .wr(req_we && is_data && unlocked),
    .idx(didx), .wdata(req_wdata), .flat(bank)
  );

  always_comb begin
    status_w = '0;
    status_w[3:0]          = VERSION;
    status_w[STAT_AUTH_BIT] = unlocked;
    status_w[STAT_IMPB_BIT] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (is_auth)      rd_mux = challenge;
    else if (is_stat) rd_mux = status_w;
    else if (is_ctl)  rd_mux = {29'd0, ctl_resume_req, ctl_halt_req, ctl_active};
    else if (is_data) rd_mux = bank[didx*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_we || req_re;
      rsp_ok    <= req_we ? wr_ok : req_re;
      rsp_rdata <= (req_re && !req_we) ? rd_mux : 32'd0;
    end
  end
endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
  parameter logic [31:0] SECRET = 32'd1
) (
  input logic        clk,
  input logic        rst,
  input logic        auth_required,
  input logic [7:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic        req_we,
  input logic        req_re,
  input logic        rsp_valid,
  input logic        rsp_ok,
  input logic [31:0] rsp_rdata,
  input logic        ctl_active,
  input logic        ctl_halt_req,
  input logic        ctl_resume_req,
  input logic        unlocked,
  input logic [31:0] challenge
);
  logic [31:0] expect_ans;
  assign expect_ans = challenge + SECRET;

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (req_we || req_re) |=> rsp_valid); // R10

  AST_LOCKED_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_we && !unlocked && req_addr != 8'h30 && req_addr != 8'h10)
      |=> (rsp_valid && !rsp_ok)); // R6

  AST_GOOD_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (req_we && req_addr == 8'h30 && auth_required && req_wdata == expect_ans)
      |=> unlocked); // R3

  AST_BAD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (req_we && req_addr == 8'h30 && auth_required && req_wdata != expect_ans)
      |=> (!unlocked && challenge != $past(challenge))); // R4

  AST_OPTIONAL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (req_we && req_addr == 8'h30 && !auth_required)
      |=> ($stable(unlocked) && $stable(challenge))); // R5

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_we && req_addr == 8'h10 && !unlocked && !(!ctl_active && req_wdata[0]))
      |=> ($stable(ctl_halt_req) && $stable(ctl_resume_req))); // R7

  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (rst)
    (req_re && !req_we && req_addr == 8'h11)
      |=> (rsp_rdata[3:0] == 4'd2 && rsp_rdata[22])); // R1

  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    req_we |=> (rsp_rdata == 32'd0)); // R10
endmodule

bind dbg_auth_gate dag_checker #(.SECRET(SECRET)) u_checker (
  .clk(clk), .rst(rst), .auth_required(auth_required), .req_addr(req_addr),
  .req_wdata(req_wdata), .req_we(req_we), .req_re(req_re),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
  .ctl_active(ctl_active), .ctl_halt_req(ctl_halt_req),
  .ctl_resume_req(ctl_resume_req), .unlocked(unlocked), .challenge(challenge)
);

// File: tb/tb_dbg_auth_gate.sv
module tb_dbg_auth_gate;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NDATA = 4;
  localparam logic [31:0] SECRET = 32'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auth_required = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_we = 1'b0, req_re = 1'b0;
  logic rsp_valid, rsp_ok;
  logic [31:0] rsp_rdata;
  logic ctl_active, ctl_halt_req, ctl_resume_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] model [NDATA];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_auth_gate #(.NDATA(NDATA), .SECRET(SECRET)) dut (
    .clk(clk), .rst(rst), .auth_required(auth_required),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we), .req_re(req_re),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
    .ctl_active(ctl_active), .ctl_halt_req(ctl_halt_req),
    .ctl_resume_req(ctl_resume_req)
  );

  function automatic logic [31:0] status_exp(input bit unl);
    logic [31:0] s = 32'd2;
    s[7]  = unl;
    s[22] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] ctl_exp(input bit a, input bit h, input bit r);
    return {29'd0, r, h, a};
  endfunction

  task automatic check(input string req, input bit pass, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!pass) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req_we = 0; req_re = 0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output bit ok);
    @(negedge clk); req_addr = a; req_wdata = d; req_we = 1'b1; req_re = 1'b0;
    @(negedge clk); req_we = 1'b0; ok = rsp_ok && rsp_valid;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output bit ok);
    @(negedge clk); req_addr = a; req_re = 1'b1; req_we = 1'b0;
    @(negedge clk); req_re = 1'b0; d = rsp_rdata; ok = rsp_ok && rsp_valid;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", checks);
    finish_run();
  end

  initial begin
    logic [31:0] v, c0, c1, c2, c3;
    bit ok;
    void'($urandom(32'd7321));

    // ---- locked mode ----
    do_reset();
    rd(8'h11, v, ok);
    check("R1 status locked", v == status_exp(0), v, status_exp(0));
    rd(8'h10, v, ok);
    check("R1 control zero", v == 32'd0, v, 32'd0);

    wr(8'h04, 32'hdead_beef, ok);
    check("R6 locked data write rejected", !ok, ok, 0);
    rd(8'h04, v, ok);
    check("R6 locked data unchanged", v == 32'd0, v, 32'd0);
    wr(8'h11, 32'hffff_ffff, ok);
    check("R10 status write rejected", !ok, ok, 0);
    rd(8'h3f, v, ok);
    check("R10 unmapped read zero ok", ok && v == 32'd0, v, 32'd0);

    rd(8'h30, c0, ok);
    rd(8'h30, v, ok);
    check("R2 challenge stable", ok && v == c0, v, c0);

    wr(8'h30, c0 + 32'd5, ok);
    check("R4 wrong answer ok", ok, ok, 1);
    rd(8'h11, v, ok);
    check("R4 still locked", v == status_exp(0), v, status_exp(0));
    rd(8'h30, c1, ok);
    check("R4 new challenge", c1 != c0, c1, c0);

    wr(8'h10, 32'h7, ok);
    check("R7 locked control ok", ok, ok, 1);
    rd(8'h10, v, ok);
    check("R7 only active taken", v == ctl_exp(1, 0, 0), v, ctl_exp(1, 0, 0));
    rd(8'h30, c2, ok);
    check("R8 activation reloads challenge", c2 != c1, c2, c1);

    // ---- unlock ----
    wr(8'h30, c2 + SECRET, ok);
    check("R3 correct answer ok", ok, ok, 1);
    rd(8'h11, v, ok);
    check("R3 unlocked", v == status_exp(1), v, status_exp(1));

    wr(8'h10, 32'h3, ok);
    rd(8'h10, v, ok);
    check("R9 halt set", ok && v == ctl_exp(1, 1, 0), v, ctl_exp(1, 1, 0));
    wr(8'h10, 32'h5, ok);
    rd(8'h10, v, ok);
    check("R9 resume set", v == ctl_exp(1, 0, 1), v, ctl_exp(1, 0, 1));
    wr(8'h10, 32'h3, ok);

    for (int i = 0; i < NDATA; i++) model[i] = 32'd0;
    for (int i = 0; i < 150; i++) begin
      int idx = int'($urandom % NDATA);
      if ($urandom % 2 == 0) begin
        logic [31:0] d = $urandom;
        wr(8'(4 + idx), d, ok);
        check("R11 data write ok", ok, ok, 1);
        model[idx] = d;
      end else begin
        rd(8'(4 + idx), v, ok);
        check("R11 data readback", v == model[idx], v, model[idx]);
      end
    end

    // ---- relock with halt pending ----
    rd(8'h30, c3, ok);
    wr(8'h30, ~(c3 + SECRET), ok);
    rd(8'h11, v, ok);
    check("R4 relocked", v == status_exp(0), v, status_exp(0));
    for (int i = 0; i < 20; i++) begin
      int idx = int'($urandom % NDATA);
      wr(8'(4 + idx), $urandom, ok);
      check("R6 locked random write rejected", !ok, ok, 0);
    end
    for (int i = 0; i < NDATA; i++) begin
      rd(8'(4 + i), v, ok);
      check("R6 data preserved", v == model[i], v, model[i]);
    end
    wr(8'h10, 32'h5, ok);
    rd(8'h10, v, ok);
    check("R7 halt kept while locked", v == ctl_exp(1, 1, 0), v, ctl_exp(1, 1, 0));
    wr(8'h10, 32'h0, ok);
    rd(8'h10, v, ok);
    check("R7 deactivate keeps halt", v == ctl_exp(0, 1, 0), v, ctl_exp(0, 1, 0));
    check("R7 halt pin", ctl_halt_req == 1'b1, ctl_halt_req, 1);
    wr(8'h10, 32'h1, ok);
    rd(8'h10, v, ok);
    check("R8 reset clears halt", v == ctl_exp(1, 0, 0), v, ctl_exp(1, 0, 0));
    rd(8'h04, v, ok);
    check("R8 reset clears data", v == 32'd0, v, 32'd0);

    // ---- optional mode ----
    auth_required = 1'b0;
    do_reset();
    rd(8'h11, v, ok);
    check("R1 status optional", v == status_exp(1), v, status_exp(1));
    rd(8'h30, c0, ok);
    wr(8'h30, c0 + 32'h1234, ok);
    check("R5 write ok", ok, ok, 1);
    rd(8'h11, v, ok);
    check("R5 still unlocked", v == status_exp(1), v, status_exp(1));
    rd(8'h30, v, ok);
    check("R5 challenge unchanged", v == c0, v, c0);
    wr(8'h07, 32'h0bad_cafe, ok);
    rd(8'h07, v, ok);
    check("R11 optional data write", v == 32'h0bad_cafe, v, 32'h0bad_cafe);
    wr(8'h10, 32'h1, ok);
    wr(8'h10, 32'h3, ok);
    check("R9 pin halt", ctl_halt_req && ctl_active, {ctl_halt_req, ctl_active}, 2'b11);
    wr(8'h10, 32'h0, ok);
    check("R9 deactivate clears", !ctl_halt_req && !ctl_resume_req && !ctl_active,
          {ctl_resume_req, ctl_halt_req, ctl_active}, 0);

    @(negedge clk); req_re = 1'b1; req_addr = 8'h11;
    @(negedge clk); req_re = 1'b0;
    check("R10 response next cycle", rsp_valid == 1'b1, rsp_valid, 1);
    @(negedge clk);
    check("R10 idle no response", rsp_valid == 1'b0, rsp_valid, 0);

    finish_run();
  end
endmodule